// File: doc/BRIEF.md
# Serial Frame Bit Encoder

This block converts a message made of whole bytes into the bitstream of one serial bus frame. A frame opens with a low start sequence that leaves the idle-high line, followed by a single high frame start bit. Each message byte then goes out behind a two-bit byte marker (high, then low), with its data bits sent most significant first. A two-bit end sequence (low, then high) closes the frame. Because every byte is preceded by a high-to-low marker, a receiver sees a falling edge at a known point in front of each byte and can realign its bit clock there.

Every frame bit is driven on the line for a fixed number of transmit clock cycles, eight by default. A one-cycle start pulse and a byte count open a frame. Bytes arrive on a valid/ready stream and pass through a one-byte holding register, so the next byte may arrive at any time during the current byte's slot. The enable output is high for exactly the cycles in which frame bits are on the line. A one-cycle done pulse follows the last of those cycles.

Top module: `serial_frame_encoder`

## Requirements
- R1: After reset and whenever no frame is in progress, tx_line is 1, tx_en is 0 and in_ready is 0. done is 0 except in the one cycle named in R7.
- R2: A frame carries the following bits in this order: LEAD_BITS (default 1) bits of 0, then one bit of 1, then for each byte the pair 1,0 followed by data bits 7 down to 0, then the pair 0,1.
- R3: Every frame bit is held for exactly CYC_PER_BIT (default 8) consecutive cycles. tx_en stays high without a break for all (LEAD_BITS + 3 + 10·count) · CYC_PER_BIT cycles of the frame.
- R4: A start that is sampled while idle opens a frame. If the count is zero, or if the first byte is accepted on the next rising edge, tx_en is high from the second cycle after the edge that sampled start.
- R5: While the first byte of a non-empty frame has not arrived, the encoder waits with tx_en at 0 and tx_line at 1. The first frame bit appears in the cycle after the edge on which that byte is accepted.
- R6: With a byte count of 0, the frame is the start sequence, the frame start bit and the end pair, with no byte slots.
- R7: done is high for exactly one cycle: the cycle right after the last transmit cycle, with tx_en already low.
- R8: A start pulse that arrives while a frame is pending or being sent has no effect on the line, the enable or the frame length.
- R9: in_ready is high only while the holding register is empty and fewer than byte_count bytes have been fetched for the current frame. Bytes offered beyond the count are not taken.
- R10: If no byte has been received by the time a slot's data bits are due, that slot is sent as eight 0 bits and counts as one of the frame's bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| byte_count | input | CNT_W | Number of message bytes, sampled with start |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Encoder accepts a byte this cycle |
| tx_line | output | 1 | Serial line level |
| tx_en | output | 1 | High while frame bits are driven |
| done | output | 1 | One-cycle pulse after the frame's last cycle |

## Verification
The bench sends frames with zero bytes, one byte and several bytes. These include data patterns with a high MSB, a low MSB and alternating bits. A design that drops or swaps a byte marker, or reverses the bit order, breaks the level compared on every cycle. The bench also holds back the first byte for a long time, pulses start in the middle of frames, withholds a last byte, and offers more bytes than the count. A design that gets these wrong would show one of four symptoms: it leaves the wait state too early, it restarts a frame, it shifts stale data into an empty slot, or it raises in_ready after all bytes are taken. Frames are also sent back to back, so a done pulse that is late or lasts more than one cycle shows up against the next frame's timing.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRIME,
        PH_LEAD,
        PH_FSTART,
        PH_BSS,
        PH_DATA,
        PH_FEND
    } phase_e;

    // Line level for a phase; idx_zero selects the first bit of a two-bit pair.
    function automatic logic level_of(phase_e ph, logic idx_zero, logic msb);
        case (ph)
            PH_LEAD:   return 1'b0;
            PH_FSTART: return 1'b1;
            PH_BSS:    return idx_zero;
            PH_DATA:   return msb;
            PH_FEND:   return !idx_zero;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sfe_bit_timer.sv
module sfe_bit_timer #(
    parameter int CYC_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic bit_end
);
    localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_BIT - 1);

    logic [CW-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cyc <= '0;
        else if (cyc == LAST)
            cyc <= '0;
        else
            cyc <= cyc + 1'b1;
    end

    assign bit_end = run && (cyc == LAST);

endmodule

// File: rtl/sfe_byte_buf.sv
module sfe_byte_buf
    import sfe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [CNT_W-1:0]  arm_count,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              take,
    output logic              in_ready,
    output logic              have_byte,
    output logic [BYTE_W-1:0] take_byte
);
    logic [CNT_W-1:0]  fetch_left;
    logic [BYTE_W-1:0] hold;
    logic              hold_full;
    logic              hs;

    assign in_ready  = !hold_full && (fetch_left != '0);
    assign hs        = in_valid && in_ready;
    assign have_byte = hold_full || hs;
    assign take_byte = hold_full ? hold : (hs ? in_data : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_left <= '0;
            hold       <= '0;
            hold_full  <= 1'b0;
        end else if (arm) begin
            fetch_left <= arm_count;
            hold_full  <= 1'b0;
        end else if (take) begin
            // Slot consumed: from the holding register, by bypass, or empty.
            if (hold_full)
                hold_full <= 1'b0;
            else if (fetch_left != '0)
                fetch_left <= fetch_left - 1'b1;
        end else if (hs) begin
            hold       <= in_data;
            hold_full  <= 1'b1;
            fetch_left <= fetch_left - 1'b1;
        end
    end

endmodule

// File: rtl/sfe_framer.sv
module sfe_framer
    import sfe_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LEAD_BITS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              bit_end,
    input  logic              have_byte,
    input  logic [BYTE_W-1:0] take_byte,
    output logic              arm,
    output logic              take,
    output logic              run,
    output logic              line,
    output logic              done
);
    localparam int IDX_MAX = (LEAD_BITS > BYTE_W) ? LEAD_BITS : BYTE_W;
    localparam int IW      = $clog2(IDX_MAX);
    localparam logic [IW-1:0] LEAD_LAST = IW'(LEAD_BITS - 1);
    localparam logic [IW-1:0] DATA_LAST = IW'(BYTE_W - 1);
    localparam logic [IW-1:0] PAIR_LAST = IW'(1);

    phase_e            phase;
    logic [IW-1:0]     idx;
    logic [CNT_W-1:0]  slot_left;
    logic [BYTE_W-1:0] shreg;

    assign arm  = (phase == PH_IDLE) && start;
    assign take = bit_end && (phase == PH_BSS) && (idx == PAIR_LAST);
    assign run  = (phase != PH_IDLE) && (phase != PH_PRIME);
    assign line = level_of(phase, idx == '0, shreg[BYTE_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            idx       <= '0;
            slot_left <= '0;
            shreg     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_PRIME;
                        slot_left <= byte_count;
                    end
                end
                PH_PRIME: begin
                    if (slot_left == '0 || have_byte) begin
                        phase <= PH_LEAD;
                        idx   <= '0;
                    end
                end
                PH_LEAD: begin
                    if (bit_end) begin
                        if (idx == LEAD_LAST) begin
                            phase <= PH_FSTART;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_FSTART: begin
                    if (bit_end) begin
                        phase <= (slot_left == '0) ? PH_FEND : PH_BSS;
                        idx   <= '0;
                    end
                end
                PH_BSS: begin
                    if (bit_end) begin
                        if (idx == PAIR_LAST) begin
                            phase     <= PH_DATA;
                            idx       <= '0;
                            shreg     <= take_byte;
                            slot_left <= slot_left - 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        shreg <= shreg << 1;
                        if (idx == DATA_LAST) begin
                            phase <= (slot_left == '0) ? PH_FEND : PH_BSS;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_FEND: begin
                    if (bit_end) begin
                        if (idx == PAIR_LAST) begin
                            phase <= PH_IDLE;
                            idx   <= '0;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serial_frame_encoder.sv
module serial_frame_encoder
    import sfe_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int LEAD_BITS   = 1,
    parameter int CYC_PER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_line,
    output logic              tx_en,
    output logic              done
);
    logic              arm;
    logic              take;
    logic              run;
    logic              bit_end;
    logic              have_byte;
    logic [BYTE_W-1:0] take_byte;

    sfe_bit_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .bit_end (bit_end)
    );

    sfe_byte_buf #(.CNT_W(CNT_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .arm_count (byte_count),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .take      (take),
        .in_ready  (in_ready),
        .have_byte (have_byte),
        .take_byte (take_byte)
    );

    sfe_framer #(.CNT_W(CNT_W), .LEAD_BITS(LEAD_BITS)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .byte_count (byte_count),
        .bit_end    (bit_end),
        .have_byte  (have_byte),
        .take_byte  (take_byte),
        .arm        (arm),
        .take       (take),
        .run        (run),
        .line       (tx_line),
        .done       (done)
    );

    assign tx_en = run;

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int CYC_PER_BIT = 8
) (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_line,
    input logic done,
    input logic in_ready
);
    localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_BIT - 1);

    // Position within the current frame bit, counted from the rise of tx_en.
    logic [CW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst || !tx_en)
            pos <= '0;
        else if (pos == LAST)
            pos <= '0;
        else
            pos <= pos + 1'b1;
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> tx_line);

    assert_lead_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> !tx_line);

    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && (tx_line != $past(tx_line))) |-> (pos == '0));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_end_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_en && $past(tx_en) && $past(tx_line)));

    assert_fetch_closed_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

endmodule

bind serial_frame_encoder sfe_checker #(.CYC_PER_BIT(CYC_PER_BIT)) u_sfe_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .tx_line  (tx_line),
    .done     (done),
    .in_ready (in_ready)
);

// File: tb/serial_frame_encoder_tb.sv
module serial_frame_encoder_tb;

    localparam int LEAD = 1;
    localparam int SPB  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] byte_count = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       tx_line;
    logic       tx_en;
    logic       done;

    always #10 clk = ~clk;

    serial_frame_encoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .byte_count (byte_count),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .tx_line    (tx_line),
        .tx_en      (tx_en),
        .done       (done)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc_n = 0;
    bit timeout = 0;

    // Stimulus state
    logic [7:0] offer_q[$];
    bit         offer_en = 1'b1;
    bit         start_req = 1'b0;
    int         start_count = 0;

    // Reference model state
    int         mstate = 0;  // 0 idle, 1 waiting, 2 sending
    int         mcount = 0;
    int         t = 0;
    bit         exp_done = 1'b0;
    bit         poked = 1'b0;
    int         used = 0;
    int         skipped = 0;
    logic [7:0] accepted[$];
    logic [7:0] slot_q[$];
    bit         slot_skip[$];

    task automatic chk(input logic got, input logic exp, input string tag);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cyc_n);
        end
    endtask

    task automatic step();
        int b, r, s, p, total;
        logic e, rdy;
        string tg;
        bit hs;
        @(negedge clk);
        cyc_n++;
        if (cyc_n > 150000 && !timeout) begin
            timeout = 1'b1;
            mismatched++;
            $display("FAIL watchdog: got running expected finished at cycle %0d", cyc_n);
        end
        rdy = (mstate != 0) && !(accepted.size() > used) &&
              ((accepted.size() + skipped) < mcount);
        // ---- compare outputs against the model ----
        case (mstate)
            0: begin
                chk(tx_en, 1'b0, "R1 tx_en idle");
                chk(tx_line, 1'b1, "R1 tx_line idle");
                chk(in_ready, 1'b0, "R1 in_ready idle");
                chk(done, exp_done, "R7 done pulse");
            end
            1: begin
                chk(tx_en, 1'b0, "R5 tx_en waiting");
                chk(tx_line, 1'b1, "R5 tx_line waiting");
                chk(done, 1'b0, "R7 done while waiting");
                chk(in_ready, rdy, "R9 in_ready waiting");
            end
            default: begin
                b = t / SPB;
                tg = (mcount == 0) ? "R6 line" : "R2 line";
                if (b < LEAD) e = 1'b0;
                else if (b == LEAD) e = 1'b1;
                else begin
                    r = b - LEAD - 1;
                    if (r < 10 * mcount) begin
                        s = r / 10;
                        p = r % 10;
                        if (p == 0) e = 1'b1;
                        else if (p == 1) e = 1'b0;
                        else begin
                            e = slot_q[s][9 - p];
                            if (slot_skip[s]) tg = "R10 empty slot";
                        end
                    end else begin
                        e = ((r - 10 * mcount) != 0);
                    end
                end
                chk(tx_line, e, tg);
                chk(tx_en, 1'b1, (t == 0) ? "R4 tx_en rise" : (poked ? "R8 tx_en" : "R3 tx_en"));
                chk(done, 1'b0, "R7 done during frame");
                chk(in_ready, rdy, "R9 in_ready sending");
            end
        endcase
        exp_done = 1'b0;
        // ---- drive inputs for the coming edge ----
        start = start_req;
        if (start_req && mstate != 0) poked = 1'b1;
        start_req = 1'b0;
        byte_count = 8'(start_count);
        in_valid = offer_en && (offer_q.size() > 0);
        in_data = in_valid ? offer_q[0] : 8'h00;
        hs = in_valid && in_ready;
        if (hs) accepted.push_back(offer_q.pop_front());
        // ---- advance the model across the coming edge ----
        case (mstate)
            0: if (start) begin
                mstate = 1;
                mcount = start_count;
                accepted.delete();
                slot_q.delete();
                slot_skip.delete();
                used = 0;
                skipped = 0;
            end
            1: if (mcount == 0 || accepted.size() > 0) begin
                mstate = 2;
                t = 0;
            end
            default: begin
                total = (LEAD + 3 + 10 * mcount) * SPB;
                b = t / SPB;
                r = b - LEAD - 1;
                if ((t % SPB) == SPB - 1 && r >= 0 && r < 10 * mcount && (r % 10) == 1) begin
                    if (accepted.size() > used) begin
                        slot_q.push_back(accepted[used]);
                        slot_skip.push_back(1'b0);
                        used++;
                    end else begin
                        slot_q.push_back(8'h00);
                        slot_skip.push_back(1'b1);
                        skipped++;
                    end
                end
                t++;
                if (t == total) begin
                    mstate = 0;
                    exp_done = 1'b1;
                end
            end
        endcase
    endtask

    task automatic run_frame(input int n, input int delay_first, input bit poke);
        int k;
        start_count = n;
        poked = 1'b0;
        if (delay_first > 0) offer_en = 1'b0;
        start_req = 1'b1;
        step();
        k = 0;
        while (mstate != 0 && !timeout) begin
            if (delay_first > 0 && k == delay_first) offer_en = 1'b1;
            if (poke && (k == 1 || k == 40)) start_req = 1'b1;
            step();
            k++;
        end
        offer_en = 1'b1;
        step();  // done pulse is compared here (R7)
        offer_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset and idle state
        repeat (4) step();
        // R2, R3, R4: three bytes with mixed MSB patterns
        offer_q = '{8'hA5, 8'h3C, 8'h81};
        run_frame(3, 0, 1'b0);
        // R6: empty message
        run_frame(0, 0, 1'b0);
        // R5, R8: late first byte and start pulses while busy
        offer_q = '{8'h0F, 8'hE2};
        run_frame(2, 25, 1'b1);
        // R10: last byte never offered
        offer_q = '{8'h55, 8'hC3};
        run_frame(3, 0, 1'b0);
        // R9: more bytes offered than counted
        offer_q = '{8'h96, 8'h7E, 8'h11, 8'h22};
        run_frame(2, 0, 1'b0);
        // Back-to-back single byte frames
        offer_q = '{8'h01};
        run_frame(1, 0, 1'b0);
        offer_q = '{8'hFE};
        run_frame(1, 0, 1'b0);
        repeat (3) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule